// File: doc/BRIEF.md
# SPI Clock and Chip-Select Delay Timebase

This block generates the timing for an SPI sequencer from the system clock. It produces serial-clock edge strobes for a frame. It also times two chip-select intervals: the setup gap between chip-select assertion and the first serial clock edge, and the hold gap between the last serial clock edge and chip-select release. The sequencer owns the shift register and the chip-select pins. It asks this block for a frame or for one of the delays and waits for the matching strobes and done pulse.

Every interval is the product of two encoded factors taken from a 32-bit attribute word. One factor is a small odd or prime prescaler. The other is a scaler that is mostly a power of two. The baud pair sets the full serial clock period. That period is split into two equal halves, and a strobe marks the end of each half. The setup and hold delays each have their own prescaler and scaler fields. The factors are latched when a request is accepted, so the attribute word may change while an interval runs.

Top module: `spi_sck_timebase`

## Requirements
- R1: The baud prescaler field `attr_i[17:16]` maps codes 0, 1, 2 and 3 to factors 2, 3, 5 and 7.
- R2: The baud scaler field `attr_i[3:0]` maps code n to 2, 4 or 6 for n = 0, 1 or 2, and to 2^n for n = 3 to 15. The serial clock period is the prescaler factor times the scaler factor in clock cycles. Its half period H is exactly half of that product.
- R3: The first strobe comes H cycles after the clock edge that samples `frame_start_i`, and each later strobe comes H cycles after the one before. Strobes alternate, starting with `sck_lead_o` and then `sck_trail_o`.
- R4: A frame issues exactly `frame_edges_i` strobes, and `frame_done_o` pulses in the same cycle as the last strobe. A request with zero edges gives `frame_done_o` in the cycle after the sampling edge and no strobes.
- R5: The setup delay uses prescaler `attr_i[23:22]`, where codes 0 to 3 give factors 1, 3, 5 and 7, and scaler `attr_i[15:12]`, where code n gives 2^(n+1). `setup_done_o` is a one-cycle pulse that starts N cycles after the edge that samples `setup_start_i`, where N is the product of the two factors.
- R6: The hold delay uses prescaler `attr_i[21:20]` and scaler `attr_i[11:8]`. It has the same encodings and timing as R5 and signals on `hold_done_o`.
- R7: The factors are captured on the edge that accepts a request. A change to `attr_i` while the interval runs has no effect on its length.
- R8: A start request to a unit that is already busy is ignored. The running interval finishes at its original time and is not retriggered.
- R9: While `rst_ni` is low, all outputs are low and every unit is idle. An interval cut short by reset never completes.
- R10: `sck_lead_o` and `sck_trail_o` are never high together. Each strobe is followed by at least one cycle with neither strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attr_i | input | 32 | Attribute word holding the baud, setup and hold scale fields |
| frame_start_i | input | 1 | Request to start the serial clock strobes for one frame |
| frame_edges_i | input | 6 | Number of strobes in the requested frame |
| setup_start_i | input | 1 | Request to start the chip-select setup delay |
| hold_start_i | input | 1 | Request to start the chip-select hold delay |
| sck_lead_o | output | 1 | Strobe at the end of the first half period |
| sck_trail_o | output | 1 | Strobe at the end of the second half period |
| frame_done_o | output | 1 | Pulse that comes with the last strobe of a frame |
| setup_done_o | output | 1 | Pulse when the setup delay has elapsed |
| hold_done_o | output | 1 | Pulse when the hold delay has elapsed |

## Verification
A table of prescaler and scaler codes is run through the baud, setup and hold paths. Each path gets a different background pattern in the unused fields, which shows that each unit reads only its own field positions. The codes include scaler values below and at the point where the baud table turns into powers of two, and the largest scaler code. These values separate the linear part of the table from the power-of-two part and expose off-by-one errors in the counters. Directed tests then check the following:
- frames with an odd number of edges and with zero edges, which test the strobe order and the done pulse;
- an attribute change during a run and a repeated start request, which test capture and retrigger protection;
- a reset during a run, which must cancel the pending completion.

// File: rtl/spi_sck_timebase_pkg.sv
package spi_sck_timebase_pkg;
  localparam int unsigned PSC_W  = 2;
  localparam int unsigned SC_W   = 4;
  localparam int unsigned MULT_W = 3;
  localparam int unsigned HALF_W = 17;  // 7 * 16384 half-period
  localparam int unsigned DLY_W  = 19;  // 7 * 65536 delay

  localparam int unsigned BAUD_PSC_LSB  = 16;
  localparam int unsigned BAUD_SC_LSB   = 0;
  localparam int unsigned SETUP_PSC_LSB = 22;
  localparam int unsigned SETUP_SC_LSB  = 12;
  localparam int unsigned HOLD_PSC_LSB  = 20;
  localparam int unsigned HOLD_SC_LSB   = 8;

  function automatic logic [MULT_W-1:0] baud_psc_mult(input logic [PSC_W-1:0] code);
    case (code)
      2'd0:    return MULT_W'(2);
      2'd1:    return MULT_W'(3);
      2'd2:    return MULT_W'(5);
      default: return MULT_W'(7);
    endcase
  endfunction

  // half of the baud scaler factor: 1,2,3 then 2^(n-1)
  function automatic logic [HALF_W-1:0] baud_sc_half(input logic [SC_W-1:0] code);
    if (code < SC_W'(3)) return HALF_W'(code) + HALF_W'(1);
    return HALF_W'(1) << (code - SC_W'(1));
  endfunction

  function automatic logic [MULT_W-1:0] dly_psc_mult(input logic [PSC_W-1:0] code);
    return {code, 1'b1};
  endfunction

  function automatic logic [DLY_W-1:0] dly_sc_mult(input logic [SC_W-1:0] code);
    return DLY_W'(2) << code;
  endfunction
endpackage

// File: rtl/spi_sck_scale_decode.sv
module spi_sck_scale_decode
  import spi_sck_timebase_pkg::*;
#(
  parameter int unsigned ATTR_W = 32
) (
  input  logic [ATTR_W-1:0] attr_i,
  output logic [HALF_W-1:0] half_cnt_o,
  output logic [DLY_W-1:0]  setup_cnt_o,
  output logic [DLY_W-1:0]  hold_cnt_o
);
  localparam logic [ATTR_W-1:0] PSC_M = ATTR_W'((1 << PSC_W) - 1);
  localparam logic [ATTR_W-1:0] SC_M  = ATTR_W'((1 << SC_W) - 1);
  localparam logic [ATTR_W-1:0] USED_MASK =
      (PSC_M << BAUD_PSC_LSB) | (SC_M << BAUD_SC_LSB) |
      (PSC_M << SETUP_PSC_LSB) | (SC_M << SETUP_SC_LSB) |
      (PSC_M << HOLD_PSC_LSB) | (SC_M << HOLD_SC_LSB);

  logic [PSC_W-1:0] baud_psc, setup_psc, hold_psc;
  logic [SC_W-1:0]  baud_sc, setup_sc, hold_sc;
  logic             unused_attr;

  assign baud_psc  = attr_i[BAUD_PSC_LSB  +: PSC_W];
  assign baud_sc   = attr_i[BAUD_SC_LSB   +: SC_W];
  assign setup_psc = attr_i[SETUP_PSC_LSB +: PSC_W];
  assign setup_sc  = attr_i[SETUP_SC_LSB  +: SC_W];
  assign hold_psc  = attr_i[HOLD_PSC_LSB  +: PSC_W];
  assign hold_sc   = attr_i[HOLD_SC_LSB   +: SC_W];
  assign unused_attr = ^(attr_i & ~USED_MASK);

  assign half_cnt_o  = HALF_W'(baud_psc_mult(baud_psc)) * baud_sc_half(baud_sc);
  assign setup_cnt_o = DLY_W'(dly_psc_mult(setup_psc)) * dly_sc_mult(setup_sc);
  assign hold_cnt_o  = DLY_W'(dly_psc_mult(hold_psc)) * dly_sc_mult(hold_sc);
endmodule

// File: rtl/spi_sck_interval.sv
module spi_sck_interval #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= load_i - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_sck_half_gen.sv
module spi_sck_half_gen #(
  parameter int unsigned HALF_W = 17,
  parameter int unsigned EDGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [EDGE_W-1:0] edges_i,
  output logic              lead_o,
  output logic              trail_o,
  output logic              done_o,
  output logic              busy_o
);
  logic [HALF_W-1:0] cnt_q, half_q;
  logic [EDGE_W-1:0] left_q;
  logic              phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      half_q  <= '0;
      left_q  <= '0;
      phase_q <= 1'b0;
      busy_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
      done_o  <= 1'b0;
      if (busy_o) begin
        if (cnt_q == '0) begin
          lead_o  <= ~phase_q;
          trail_o <= phase_q;
          phase_q <= ~phase_q;
          left_q  <= left_q - 1'b1;
          cnt_q   <= half_q - 1'b1;
          if (left_q == EDGE_W'(1)) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_i) begin
        if (edges_i == '0) begin
          done_o <= 1'b1;
        end else begin
          busy_o  <= 1'b1;
          cnt_q   <= half_i - 1'b1;
          half_q  <= half_i;
          left_q  <= edges_i;
          phase_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_sck_timebase.sv
module spi_sck_timebase
  import spi_sck_timebase_pkg::*;
#(
  parameter int unsigned ATTR_W = 32,
  parameter int unsigned EDGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic              frame_start_i,
  input  logic [EDGE_W-1:0] frame_edges_i,
  input  logic              setup_start_i,
  input  logic              hold_start_i,
  output logic              sck_lead_o,
  output logic              sck_trail_o,
  output logic              frame_done_o,
  output logic              setup_done_o,
  output logic              hold_done_o
);
  localparam int unsigned N_DLY = 2;

  logic [HALF_W-1:0] half_cnt;
  logic [DLY_W-1:0]  dly_load [N_DLY];
  logic              dly_start[N_DLY];
  logic              dly_done [N_DLY];
  logic              frame_busy;

  spi_sck_scale_decode #(.ATTR_W(ATTR_W)) u_decode (
    .attr_i      (attr_i),
    .half_cnt_o  (half_cnt),
    .setup_cnt_o (dly_load[0]),
    .hold_cnt_o  (dly_load[1])
  );

  spi_sck_half_gen #(.HALF_W(HALF_W), .EDGE_W(EDGE_W)) u_half (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (frame_start_i),
    .half_i  (half_cnt),
    .edges_i (frame_edges_i),
    .lead_o  (sck_lead_o),
    .trail_o (sck_trail_o),
    .done_o  (frame_done_o),
    .busy_o  (frame_busy)
  );

  assign dly_start[0] = setup_start_i;
  assign dly_start[1] = hold_start_i;

  for (genvar g = 0; g < N_DLY; g++) begin : g_dly
    spi_sck_interval #(.CNT_W(DLY_W)) u_ivl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (dly_start[g]),
      .load_i  (dly_load[g]),
      .done_o  (dly_done[g])
    );
  end

  assign setup_done_o = dly_done[0];
  assign hold_done_o  = dly_done[1];
endmodule

// File: rtl/spi_sck_timebase_checker.sv
module spi_sck_timebase_checker #(
  parameter int unsigned EDGE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_start_i,
  input logic [EDGE_W-1:0] frame_edges_i,
  input logic              frame_busy,
  input logic              sck_lead_o,
  input logic              sck_trail_o,
  input logic              frame_done_o,
  input logic              setup_done_o,
  input logic              hold_done_o
);
  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_lead_o && sck_trail_o));

  assert_lead_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_lead_o |=> !(sck_lead_o || sck_trail_o));

  assert_trail_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_trail_o |=> !(sck_lead_o || sck_trail_o));

  assert_zero_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !frame_busy && frame_edges_i == '0)
      |=> (frame_done_o && !sck_lead_o && !sck_trail_o));

  assert_done_with_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_o && $past(frame_busy)) |-> (sck_lead_o || sck_trail_o));

  assert_setup_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_done_o |=> !setup_done_o);

  assert_hold_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_done_o |=> !hold_done_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R9: assert (!sck_lead_o && !sck_trail_o && !frame_done_o
                                     && !setup_done_o && !hold_done_o);
    end
  end
endmodule

bind spi_sck_timebase spi_sck_timebase_checker #(.EDGE_W(EDGE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .frame_edges_i (frame_edges_i),
  .frame_busy    (frame_busy),
  .sck_lead_o    (sck_lead_o),
  .sck_trail_o   (sck_trail_o),
  .frame_done_o  (frame_done_o),
  .setup_done_o  (setup_done_o),
  .hold_done_o   (hold_done_o)
);

// File: tb/spi_sck_timebase_test.sv
`timescale 1ns/1ps
module spi_sck_timebase_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] attr_i = '0;
  logic        frame_start_i = 1'b0;
  logic [5:0]  frame_edges_i = '0;
  logic        setup_start_i = 1'b0;
  logic        hold_start_i = 1'b0;
  logic        sck_lead_o, sck_trail_o, frame_done_o, setup_done_o, hold_done_o;

  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;

  always #2.5 clk_i = ~clk_i;

  spi_sck_timebase uut (
    .clk_i, .rst_ni, .attr_i, .frame_start_i, .frame_edges_i,
    .setup_start_i, .hold_start_i, .sck_lead_o, .sck_trail_o,
    .frame_done_o, .setup_done_o, .hold_done_o
  );

  // unit: 0 baud (cnt = half period), 1 setup, 2 hold (cnt = delay)
  typedef struct packed {
    logic [1:0]  unit;
    logic [1:0]  psc;
    logic [3:0]  sc;
    logic [31:0] cnt;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS[NV] = '{
    '{2'd0, 2'd0, 4'd0, 32'd2},
    '{2'd0, 2'd1, 4'd0, 32'd3},
    '{2'd0, 2'd2, 4'd1, 32'd10},
    '{2'd0, 2'd3, 4'd2, 32'd21},
    '{2'd0, 2'd0, 4'd3, 32'd8},
    '{2'd0, 2'd1, 4'd5, 32'd48},
    '{2'd0, 2'd3, 4'd4, 32'd56},
    '{2'd1, 2'd0, 4'd0, 32'd2},
    '{2'd1, 2'd1, 4'd0, 32'd6},
    '{2'd1, 2'd2, 4'd3, 32'd80},
    '{2'd1, 2'd3, 4'd2, 32'd56},
    '{2'd1, 2'd0, 4'd6, 32'd128},
    '{2'd2, 2'd0, 4'd1, 32'd4},
    '{2'd2, 2'd3, 4'd0, 32'd14},
    '{2'd2, 2'd1, 4'd4, 32'd96},
    '{2'd2, 2'd2, 4'd2, 32'd40}
  };

  function automatic logic [31:0] make_attr(input int unit, input logic [1:0] psc,
                                            input logic [3:0] sc, input logic [31:0] base);
    logic [31:0] a = base;
    case (unit)
      0: begin a[17:16] = psc; a[3:0]   = sc; end
      1: begin a[23:22] = psc; a[15:12] = sc; end
      default: begin a[21:20] = psc; a[11:8] = sc; end
    endcase
    return a;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit unit_done(input int unit);
    return (unit == 1) ? setup_done_o : hold_done_o;
  endfunction

  task automatic set_start(input int unit, input bit v);
    if (unit == 1) setup_start_i = v;
    else hold_start_i = v;
  endtask

  task automatic run_delay(input int unit, input logic [31:0] attr, input int exp,
                           input logic [31:0] attr_mid, input int restart_at,
                           input string req);
    int n = 0;
    int got = -1;
    @(negedge clk_i);
    attr_i = attr;
    set_start(unit, 1'b1);
    @(posedge clk_i);
    @(negedge clk_i);
    set_start(unit, 1'b0);
    attr_i = attr_mid;
    while (got < 0 && n <= exp + 4) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      set_start(unit, n == restart_at);
      if (unit_done(unit)) got = n;
    end
    set_start(unit, 1'b0);
    check(got == exp, req, "delay length", got, exp);
    @(posedge clk_i);
    @(negedge clk_i);
    check(!unit_done(unit), req, "done pulse width", int'(unit_done(unit)), 0);
  endtask

  task automatic run_frame(input logic [31:0] attr, input int edges, input int h,
                           input logic [31:0] attr_mid, input string req);
    int n = 0;
    int strobes = 0;
    @(negedge clk_i);
    attr_i = attr;
    frame_edges_i = 6'(edges);
    frame_start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    frame_start_i = 1'b0;
    attr_i = attr_mid;
    if (edges == 0) begin
      check(frame_done_o && !sck_lead_o && !sck_trail_o, "R4", "zero-edge done",
            int'(frame_done_o), 1);
      @(posedge clk_i);
      @(negedge clk_i);
      check(!frame_done_o, "R4", "zero-edge done width", int'(frame_done_o), 0);
      return;
    end
    while (strobes < edges && n <= edges * h + 4) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (sck_lead_o || sck_trail_o) begin
        strobes++;
        check(n == strobes * h, req, "R3 strobe time", n, strobes * h);
        check(sck_lead_o == strobes[0], "R3", "strobe kind is lead", int'(sck_lead_o),
              int'(strobes[0]));
        check(frame_done_o == (strobes == edges), "R4", "done with last strobe",
              int'(frame_done_o), int'(strobes == edges));
      end
    end
    check(strobes == edges, "R4", "strobe count", strobes, edges);
    repeat (h + 2) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (sck_lead_o || sck_trail_o || frame_done_o) strobes++;
    end
    check(strobes == edges, "R4", "no strobes after frame", strobes, edges);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] a;
    int n;
    int seen;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(!sck_lead_o && !sck_trail_o && !frame_done_o && !setup_done_o && !hold_done_o,
          "R9", "outputs in reset", int'(sck_lead_o | setup_done_o | hold_done_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      a = make_attr(int'(VECS[i].unit), VECS[i].psc, VECS[i].sc,
                    (i % 2 == 1) ? 32'hFFFF_FFFF : 32'h0);
      case (VECS[i].unit)
        2'd0: run_frame(a, 2, int'(VECS[i].cnt), a, "R1 R2");
        2'd1: run_delay(1, a, int'(VECS[i].cnt), a, -1, "R5");
        default: run_delay(2, a, int'(VECS[i].cnt), a, -1, "R6");
      endcase
    end

    // odd edge count, strobe order
    a = make_attr(0, 2'd1, 4'd0, 32'h0);
    run_frame(a, 5, 3, a, "R3");
    run_frame(a, 0, 3, a, "R4");

    // baud factors captured at start
    run_frame(a, 4, 3, make_attr(0, 2'd3, 4'd4, 32'h0), "R7");

    // delay factors captured at start
    run_delay(1, make_attr(1, 2'd1, 4'd0, 32'h0), 6,
              make_attr(1, 2'd0, 4'd6, 32'h0), -1, "R7");

    // start while busy is ignored
    a = make_attr(1, 2'd2, 4'd3, 32'h0);
    run_delay(1, a, 80, a, 10, "R8");
    a = make_attr(2, 2'd1, 4'd0, 32'h0);
    run_delay(2, a, 6, a, 3, "R8");

    // scaler extremes
    run_frame(make_attr(0, 2'd0, 4'd15, 32'h0), 1, 32768, 32'h0, "R2");
    run_delay(2, make_attr(2, 2'd0, 4'd15, 32'h0), 65536, 32'h0, -1, "R6");

    // reset during a running delay
    @(negedge clk_i);
    attr_i = make_attr(1, 2'd0, 4'd6, 32'h0);
    setup_start_i = 1'b1;
    @(negedge clk_i);
    setup_start_i = 1'b0;
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(!setup_done_o && !sck_lead_o, "R9", "outputs after mid reset",
          int'(setup_done_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    seen = 0;
    for (n = 0; n < 200; n++) begin
      @(negedge clk_i);
      if (setup_done_o) seen++;
    end
    check(seen == 0, "R9", "cancelled delay never completes", seen, 0);

    finish_run();
  end
endmodule